// File: doc/BRIEF.md
# Privilege and Stack Select Controller

This block keeps the thread-mode control state of a processor core and the two banked stack pointers, one for the kernel and exception handlers (main) and one for application threads (process). From that state it derives which privilege level the core runs at, which stack pointer is active and what value it holds. It also tells the exception logic whether the next exception must push a long frame, meaning the integer registers plus the floating-point registers, or a short frame of integer registers only.

The core is in one of two modes. In thread mode, two control bits choose the privilege level and the stack pointer. In handler mode the core is always privileged and always uses the main pointer. Exception entry and exception return strobes move the core between the two modes. The return code carries the target mode, the thread stack choice and the frame type. A floating-point context flag is set when a floating-point instruction retires, cleared on exception entry and restored from the return code. Unprivileged thread code cannot change the control bits. The only way back to privilege is an exception whose handler clears the privilege bit.

Top module: `priv_stack_ctrl`

## Requirements
- R1: After reset the core is in thread mode and privileged. It uses the main pointer. Control reads return 0, the frame type is short, and both stack pointers are 0.
- R2: In thread mode, control bit 0 sets privilege: 0 gives privileged (`priv_eff`=1) and 1 gives unprivileged (`priv_eff`=0).
- R3: In thread mode, control bit 1 selects the stack: 0 selects the main pointer and 1 selects the process pointer (`sp_is_proc`=1).
- R4: In handler mode `priv_eff` is 1 and `sp_is_proc` is 0, whatever the control bits hold.
- R5: A control write made while `priv_eff` is 0 changes no control bit.
- R6: An `exc_entry` strobe puts the core in handler mode. An `exc_return` strobe whose return code has bit 3 set goes back to thread mode and copies code bit 2 into control bit 1. With code bit 3 clear, the core stays in handler mode and control bit 1 is unchanged.
- R7: Control bit 2, the floating-point context flag, is set by an `fp_exec` strobe and cleared by `exc_entry`.
- R8: On exception return, control bit 2 becomes the inverse of return-code bit 4. `frame_long` equals control bit 2: 1 means a long frame and 0 means a short frame.
- R9: A handler that clears control bit 0 and then returns to thread mode leaves the thread privileged.
- R10: A stack pointer write updates only the active pointer, with its two low bits forced to 0. `sp_value` shows the active pointer.
- R11: While privileged, a control read returns bits 2:0 with all upper bits 0. While unprivileged, a read returns 0.
- R12: In one cycle, `exc_entry` wins over `exc_return`, and either strobe blocks a control write. A control write wins over `fp_exec` for bit 2. A stack pointer write in a cycle that changes the mode goes to the pointer that was active before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | DATA_W | Control write data; bits 2:0 used |
| ctl_rd_data | output | DATA_W | Control read data |
| exc_entry | input | 1 | Exception entry strobe |
| exc_return | input | 1 | Exception return strobe |
| exc_ret_code | input | RET_W | Return code: bit 2 thread stack, bit 3 to thread, bit 4 short frame |
| fp_exec | input | 1 | A floating-point instruction retired |
| sp_wr_en | input | 1 | Active stack pointer write strobe |
| sp_wr_data | input | SP_W | Stack pointer write data |
| handler_mode | output | 1 | 1 in handler mode |
| priv_eff | output | 1 | 1 when the core is privileged |
| sp_is_proc | output | 1 | 1 when the process pointer is active |
| sp_value | output | SP_W | Value of the active stack pointer |
| frame_long | output | 1 | Next exception pushes a long frame |

## Verification
The hardest state to reach is the recovery path. Thread code must first be unprivileged on the process stack. It must then fail to undo that itself. An exception must follow, the handler must clear the privilege bit, and a return must restore privilege. The vector table walks this chain one strobe at a time and checks every output after each step. Same-cycle collisions are also vectors of their own: entry together with return, and a control write together with a stack pointer write that swaps pointers.

// File: rtl/psc_pkg.sv
package psc_pkg;
  // control bit positions
  localparam int CTL_NPRIV = 0;
  localparam int CTL_SPSEL = 1;
  localparam int CTL_FPCTX = 2;
  localparam int CTL_BITS  = 3;
  // return code bit positions
  localparam int RET_SPSEL  = 2;
  localparam int RET_THREAD = 3;
  localparam int RET_SHORT  = 4;
  localparam int RET_MIN_W  = 5;

  typedef enum logic {MODE_THREAD = 1'b0, MODE_HANDLER = 1'b1} mode_e;

  function automatic logic eff_priv(mode_e mode, logic npriv);
    return (mode == MODE_HANDLER) || !npriv;
  endfunction

  function automatic logic sel_proc(mode_e mode, logic spsel);
    return (mode == MODE_THREAD) && spsel;
  endfunction

  function automatic logic long_frame(logic ret_short);
    return !ret_short;
  endfunction
endpackage

// File: rtl/psc_mode_ctl.sv
module psc_mode_ctl
  import psc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctl_wr_en,
  input  logic  wr_npriv,
  input  logic  wr_spsel,
  input  logic  exc_entry,
  input  logic  exc_return,
  input  logic  ret_thread,
  input  logic  ret_spsel,
  output mode_e mode,
  output logic  npriv,
  output logic  spsel,
  output logic  priv_now,
  output logic  ctl_wr_ok
);
  mode_e mode_q;
  logic  npriv_q, spsel_q;
  logic  ev_ret, ev_ret_thread;

  assign priv_now      = eff_priv(mode_q, npriv_q);
  assign ev_ret        = exc_return && !exc_entry;
  assign ev_ret_thread = ev_ret && ret_thread;
  assign ctl_wr_ok     = ctl_wr_en && priv_now && !exc_entry && !exc_return;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_THREAD;
      npriv_q <= 1'b0;
      spsel_q <= 1'b0;
    end else if (exc_entry) begin
      mode_q <= MODE_HANDLER;
    end else if (ev_ret_thread) begin
      mode_q  <= MODE_THREAD;
      spsel_q <= ret_spsel;
    end else if (ctl_wr_ok) begin
      npriv_q <= wr_npriv;
      spsel_q <= wr_spsel;
    end
  end

  assign mode  = mode_q;
  assign npriv = npriv_q;
  assign spsel = spsel_q;

  AST_UNPRIV_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_en && !priv_now && !exc_entry && !exc_return) |=> ($stable(npriv_q) && $stable(spsel_q))); // R5
  AST_RET_TO_THREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && !exc_entry && ret_thread) |=> (mode_q == MODE_THREAD && spsel_q == $past(ret_spsel))); // R6
  AST_RET_STAY_HANDLER: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && !ret_thread && mode_q == MODE_HANDLER) |=> (mode_q == MODE_HANDLER && $stable(spsel_q))); // R6
  AST_ENTRY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_entry && exc_return) |=> (mode_q == MODE_HANDLER)); // R12
endmodule

// File: rtl/psc_fp_ctx.sv
module psc_fp_ctx
  import psc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic exc_entry,
  input  logic exc_return,
  input  logic ret_short,
  input  logic ctl_wr_ok,
  input  logic wr_fpctx,
  input  logic fp_exec,
  output logic fpctx,
  output logic frame_long
);
  logic fp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fp_q <= 1'b0;
    else if (exc_entry)  fp_q <= 1'b0;
    else if (exc_return) fp_q <= long_frame(ret_short);
    else if (ctl_wr_ok)  fp_q <= wr_fpctx;
    else if (fp_exec)    fp_q <= 1'b1;
  end

  assign fpctx      = fp_q;
  assign frame_long = fp_q;

  AST_FP_ENTRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |=> !fp_q); // R7
  AST_FP_EXEC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_exec && !exc_entry && !exc_return && !ctl_wr_ok) |=> fp_q); // R7
  AST_FP_RET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && !exc_entry) |=> (fp_q == !$past(ret_short))); // R8
endmodule

// File: rtl/psc_sp_bank.sv
module psc_sp_bank #(
  parameter int SP_W   = 32,
  parameter int NUM_SP = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sp_wr_en,
  input  logic [SP_W-1:0] sp_wr_data,
  input  logic            use_proc,
  output logic [SP_W-1:0] sp_value
);
  localparam int SEL_W = (NUM_SP > 1) ? $clog2(NUM_SP) : 1;

  logic [SP_W-1:0] sp_q [NUM_SP];
  logic [SEL_W-1:0] sel;

  function automatic logic [SP_W-1:0] word_align(logic [SP_W-1:0] v);
    return {v[SP_W-1:2], 2'b00};
  endfunction

  assign sel = SEL_W'(use_proc);

  for (genvar i = 0; i < NUM_SP; i++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sp_q[i] <= '0;
      else if (sp_wr_en && sel == SEL_W'(i))
        sp_q[i] <= word_align(sp_wr_data);
    end

    AST_SP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      sp_q[i][1:0] == 2'b00); // R10
    AST_SP_INACTIVE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_wr_en && sel != SEL_W'(i)) |=> $stable(sp_q[i])); // R10
  end

  assign sp_value = sp_q[sel];
endmodule

// File: rtl/priv_stack_ctrl.sv
module priv_stack_ctrl
  import psc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RET_W  = 5,
  parameter int SP_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr_en,
  input  logic [DATA_W-1:0] ctl_wr_data,
  output logic [DATA_W-1:0] ctl_rd_data,
  input  logic              exc_entry,
  input  logic              exc_return,
  input  logic [RET_W-1:0]  exc_ret_code,
  input  logic              fp_exec,
  input  logic              sp_wr_en,
  input  logic [SP_W-1:0]   sp_wr_data,
  output logic              handler_mode,
  output logic              priv_eff,
  output logic              sp_is_proc,
  output logic [SP_W-1:0]   sp_value,
  output logic              frame_long
);
  localparam int PAD_W = DATA_W - CTL_BITS;

  mode_e mode;
  logic  npriv, spsel, fpctx, priv_now, ctl_wr_ok, use_proc;
  logic  [CTL_BITS-1:0] ctl_bits;
  logic  unused_wr_bits, unused_ret_bits;

  assign unused_wr_bits  = ^ctl_wr_data;
  assign unused_ret_bits = ^exc_ret_code;

  psc_mode_ctl u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr_en (ctl_wr_en),
    .wr_npriv  (ctl_wr_data[CTL_NPRIV]),
    .wr_spsel  (ctl_wr_data[CTL_SPSEL]),
    .exc_entry (exc_entry),
    .exc_return(exc_return),
    .ret_thread(exc_ret_code[RET_THREAD]),
    .ret_spsel (exc_ret_code[RET_SPSEL]),
    .mode      (mode),
    .npriv     (npriv),
    .spsel     (spsel),
    .priv_now  (priv_now),
    .ctl_wr_ok (ctl_wr_ok)
  );

  psc_fp_ctx u_fp (
    .clk       (clk),
    .rst_n     (rst_n),
    .exc_entry (exc_entry),
    .exc_return(exc_return),
    .ret_short (exc_ret_code[RET_SHORT]),
    .ctl_wr_ok (ctl_wr_ok),
    .wr_fpctx  (ctl_wr_data[CTL_FPCTX]),
    .fp_exec   (fp_exec),
    .fpctx     (fpctx),
    .frame_long(frame_long)
  );

  assign use_proc = sel_proc(mode, spsel);

  psc_sp_bank #(.SP_W(SP_W), .NUM_SP(2)) u_sp (
    .clk       (clk),
    .rst_n     (rst_n),
    .sp_wr_en  (sp_wr_en),
    .sp_wr_data(sp_wr_data),
    .use_proc  (use_proc),
    .sp_value  (sp_value)
  );

  always_comb begin
    ctl_bits            = '0;
    ctl_bits[CTL_NPRIV] = npriv;
    ctl_bits[CTL_SPSEL] = spsel;
    ctl_bits[CTL_FPCTX] = fpctx;
  end

  assign ctl_rd_data  = priv_now ? {{PAD_W{1'b0}}, ctl_bits} : '0;
  assign handler_mode = (mode == MODE_HANDLER);
  assign priv_eff     = priv_now;
  assign sp_is_proc   = use_proc;

  AST_ENTRY_PRIV_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |=> (handler_mode && priv_eff && !sp_is_proc)); // R4
  AST_UNPRIV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!handler_mode && ctl_wr_en && ctl_wr_data[CTL_NPRIV] && priv_eff && !exc_entry && !exc_return)
      |=> (ctl_rd_data == '0)); // R11
endmodule

// File: tb/priv_stack_ctrl_test.sv
`timescale 1ns/1ps
module priv_stack_ctrl_test;
  localparam int DW = 32;
  localparam int RW = 5;
  localparam int SW = 32;
  localparam int NV = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctl_wr_en = 1'b0;
  logic [DW-1:0] ctl_wr_data = '0;
  logic [DW-1:0] ctl_rd_data;
  logic          exc_entry = 1'b0, exc_return = 1'b0, fp_exec = 1'b0, sp_wr_en = 1'b0;
  logic [RW-1:0] exc_ret_code = '0;
  logic [SW-1:0] sp_wr_data = '0;
  logic          handler_mode, priv_eff, sp_is_proc, frame_long;
  logic [SW-1:0] sp_value;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  priv_stack_ctrl #(.DATA_W(DW), .RET_W(RW), .SP_W(SW)) uut (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
    .exc_entry(exc_entry), .exc_return(exc_return), .exc_ret_code(exc_ret_code),
    .fp_exec(fp_exec), .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data),
    .handler_mode(handler_mode), .priv_eff(priv_eff), .sp_is_proc(sp_is_proc),
    .sp_value(sp_value), .frame_long(frame_long)
  );

  // stimulus: wr, wdata[2:0], entry, return, code{b4,b3,b2}, fp, spwr, spdata
  // expected: {handler,priv,proc,long}, rd[2:0], sp
  localparam logic [33:0] VEC [NV] = '{
    {1'b0,3'b000,1'b0,1'b0,3'b000,1'b0,1'b1,8'h43, 4'b0100,3'b000,8'h40}, // R10 main write
    {1'b1,3'b010,1'b0,1'b0,3'b000,1'b0,1'b0,8'h00, 4'b0110,3'b010,8'h00}, // R3 select process
    {1'b0,3'b000,1'b0,1'b0,3'b000,1'b0,1'b1,8'h81, 4'b0110,3'b010,8'h80}, // R10 process write
    {1'b0,3'b000,1'b0,1'b0,3'b000,1'b1,1'b0,8'h00, 4'b0111,3'b110,8'h80}, // R7 fp set
    {1'b1,3'b011,1'b0,1'b0,3'b000,1'b0,1'b0,8'h00, 4'b0010,3'b000,8'h80}, // R2 drop privilege
    {1'b1,3'b000,1'b0,1'b0,3'b000,1'b0,1'b0,8'h00, 4'b0010,3'b000,8'h80}, // R5 ignored write
    {1'b0,3'b000,1'b0,1'b0,3'b000,1'b1,1'b0,8'h00, 4'b0011,3'b000,8'h80}, // R7 fp set, R11 read zero
    {1'b0,3'b000,1'b1,1'b0,3'b000,1'b0,1'b0,8'h00, 4'b1100,3'b011,8'h40}, // R4 R6 R7 entry
    {1'b0,3'b000,1'b0,1'b0,3'b000,1'b0,1'b1,8'h5E, 4'b1100,3'b011,8'h5C}, // R10 handler writes main
    {1'b1,3'b010,1'b0,1'b0,3'b000,1'b0,1'b0,8'h00, 4'b1100,3'b010,8'h5C}, // R9 clear bit 0
    {1'b0,3'b000,1'b0,1'b1,3'b011,1'b0,1'b0,8'h00, 4'b0111,3'b110,8'h80}, // R6 R8 R9 return long
    {1'b0,3'b000,1'b1,1'b1,3'b110,1'b0,1'b0,8'h00, 4'b1100,3'b010,8'h5C}, // R12 entry wins
    {1'b0,3'b000,1'b0,1'b1,3'b001,1'b0,1'b0,8'h00, 4'b1101,3'b110,8'h5C}, // R6 stay handler, R8
    {1'b0,3'b000,1'b0,1'b1,3'b110,1'b0,1'b0,8'h00, 4'b0100,3'b000,8'h5C}, // R6 R8 return short main
    {1'b1,3'b111,1'b0,1'b0,3'b000,1'b0,1'b1,8'hFF, 4'b0011,3'b000,8'h80}, // R12 sp write pre-edge pointer
    {1'b0,3'b000,1'b0,1'b0,3'b000,1'b0,1'b1,8'h23, 4'b0011,3'b000,8'h20}, // R10 unpriv process write
    {1'b0,3'b000,1'b1,1'b0,3'b000,1'b0,1'b0,8'h00, 4'b1100,3'b011,8'hFC}  // R4 R10 main kept
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [3:0] hpsf, input logic [31:0] rd, input logic [31:0] sp);
    check(req, "handler_mode", 32'(handler_mode), 32'(hpsf[3]));
    check(req, "priv_eff",     32'(priv_eff),     32'(hpsf[2]));
    check(req, "sp_is_proc",   32'(sp_is_proc),   32'(hpsf[1]));
    check(req, "frame_long",   32'(frame_long),   32'(hpsf[0]));
    check(req, "ctl_rd_data",  ctl_rd_data,       rd);
    check(req, "sp_value",     sp_value,          sp);
  endtask

  task automatic clear_in();
    ctl_wr_en = 1'b0; ctl_wr_data = '0; exc_entry = 1'b0; exc_return = 1'b0;
    exc_ret_code = '0; fp_exec = 1'b0; sp_wr_en = 1'b0; sp_wr_data = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    clear_in();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_all("R1", 4'b0100, 32'h0, 32'h0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      v = VEC[i];
      @(negedge clk);
      ctl_wr_en    = v[33];
      ctl_wr_data  = {29'b0, v[32:30]};
      exc_entry    = v[29];
      exc_return   = v[28];
      exc_ret_code = {v[27:25], 2'b00};
      fp_exec      = v[24];
      sp_wr_en     = v[23];
      sp_wr_data   = {24'b0, v[22:15]};
      tick();
      check_all($sformatf("R2-table vector %0d", i), v[14:11], {29'b0, v[10:8]}, {24'b0, v[7:0]});
    end

    // R11: upper write bits ignored, read shows only bits 2:0 (core is in handler mode)
    @(negedge clk);
    ctl_wr_en = 1'b1; ctl_wr_data = 32'hFFFF_FFF6;
    tick();
    check("R11", "ctl_rd_data", ctl_rd_data, 32'h6);
    check("R8", "frame_long", 32'(frame_long), 32'h1);

    // R9: return to thread with bit 0 clear keeps privilege, short frame, main stack
    @(negedge clk);
    exc_return = 1'b1; exc_ret_code = 5'b11000;
    tick();
    check_all("R9", 4'b0100, 32'h0, 32'hFC);

    // R1: reset mid-run restores the reset state
    @(negedge clk) rst_n = 1'b0;
    #1;
    check_all("R1", 4'b0100, 32'h0, 32'h0);
    @(negedge clk) rst_n = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule